// File: doc/BRIEF.md
# Seconds Counter with Programmable Periodic Interrupt

This block keeps a running count of seconds and raises a periodic interrupt. Both are driven by one enable pulse at a fixed base rate. A prescaler turns that pulse into whole seconds. Software reads the 33-bit seconds value through three 16-bit registers. The split between the registers is uneven: the least significant bit sits alone at the top of the first register.

Software sets the interrupt rate by writing a divisor N. A reloadable down-counter then produces one periodic tick for every N base pulses. Ticks are not held in one sticky flag. They go into a saturating pending counter, and the interrupt line stays high while that count is non-zero. Each access to the acknowledge register retires one tick. The line drops for one cycle after every acknowledge, so the interrupt controller sees a fresh edge for each tick that is still outstanding.

Top module: `rtc_tick_unit`

## Requirements
- R1: After reset the seconds count is zero. It advances by one after every SEC_DIV base pulses and never decreases.
- R2: A read at offset 0xC0 returns seconds bit 0 in bit 15, with bits 14:0 zero.
- R3: A read at offset 0xC2 returns seconds bits 16:1. A read at offset 0xC4 returns seconds bits 32:17.
- R4: A write of a non-zero N to offset 0xD0 loads the divisor. The first periodic tick comes on the N-th base pulse after the write, and a tick follows every N base pulses after that.
- R5: A write of zero to 0xD0 leaves the divisor and the countdown phase unchanged. A write to 0xD2 has no effect.
- R6: Until a non-zero divisor has been written, no periodic tick occurs and the interrupt stays low.
- R7: Each periodic tick adds one to the pending count. The interrupt output is high one cycle after the count becomes non-zero.
- R8: A read or write at the acknowledge offset (ACK_OFF, default 0x1DE) removes one pending tick if any remain. The interrupt is low in the cycle after the access and returns in the following cycle if ticks are still pending.
- R9: The pending count is 8 bits wide and holds at 255 instead of wrapping. Exactly 255 acknowledges are then needed to clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_tick | input | 1 | One-cycle pulse at the base rate |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational, zero when not reading) |
| irq | output | 1 | Periodic interrupt request |

## Verification
The hardest state to reach is pending-count saturation followed by a complete drain. The stimulus sets the divisor to 1, so every base pulse becomes a tick, and drives 300 pulses. It then acknowledges 255 times and checks the interrupt gap and re-assertion after every access, and that the line stays low after the last one. The upper seconds register only changes after 2^17 seconds. To reach it, the bench sets the prescaler to one pulse per second and holds the base pulse high for over 131072 cycles.

// File: rtl/rtc_pkg.sv
// Shared register offsets and widths of the seconds/periodic-interrupt block.
// Assumes byte offsets on a 12-bit register bus with 16-bit data.
package rtc_pkg;
    localparam int REG_W   = 16;
    localparam int SEC_W   = 2 * REG_W + 1;
    localparam int PEND_W  = 8;
    localparam logic [11:0] OFF_SEC_LO  = 12'h0C0;
    localparam logic [11:0] OFF_SEC_MID = 12'h0C2;
    localparam logic [11:0] OFF_SEC_HI  = 12'h0C4;
    localparam logic [11:0] OFF_RATE    = 12'h0D0;
    localparam logic [11:0] OFF_RATE_HI = 12'h0D2;
endpackage

// File: rtl/rtc_sec_counter.sv
// Seconds counter: a prescaler counts base pulses and bumps the seconds
// value once every SEC_DIV of them. Assumes SEC_DIV >= 1.
module rtc_sec_counter #(
    parameter int SEC_DIV = 32768,
    parameter int SEC_W   = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick,
    output logic [SEC_W-1:0] sec_o
);
    localparam int PRE_W = (SEC_DIV > 1) ? $clog2(SEC_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SEC_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic [SEC_W-1:0] sec_q;

    // Prescale base pulses and advance the seconds count on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            sec_q <= '0;
        end else if (base_tick) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                sec_q <= sec_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign sec_o = sec_q;
endmodule

// File: rtl/rtc_rate_divider.sv
// Periodic tick generator: a down-counter reloaded with divisor N emits a
// tick on every N-th base pulse. Idle until a non-zero divisor is loaded.
module rtc_rate_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick,
    input  logic             load_i,
    input  logic [DIV_W-1:0] div_i,
    output logic [DIV_W-1:0] div_o,
    output logic             tick_o
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;
    logic             active_q;
    logic             last;

    assign last = (cnt_q == DIV_W'(1));

    // Load a new divisor or count base pulses down, reloading at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (load_i) begin
            div_q    <= div_i;
            cnt_q    <= div_i;
            active_q <= 1'b1;
        end else if (active_q && base_tick) begin
            cnt_q <= last ? div_q : cnt_q - 1'b1;
        end
    end

    assign tick_o = active_q && base_tick && last && !load_i;
    assign div_o  = div_q;
endmodule

// File: rtl/rtc_pending_ctr.sv
// Pending-tick counter: adds periodic ticks, removes one per acknowledge,
// saturates at its maximum. Drives the interrupt from the next count and
// blanks it for the cycle following an acknowledge.
module rtc_pending_ctr #(
    parameter int PEND_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              ack_i,
    output logic [PEND_W-1:0] count_o,
    output logic              irq_o
);
    localparam logic [PEND_W:0] PEND_MAX = {1'b0, {PEND_W{1'b1}}};

    logic [PEND_W-1:0] cnt_q;
    logic              irq_q;
    logic [PEND_W:0]   sum;
    logic [PEND_W-1:0] cnt_d;

    // Next count: add tick, drop one on acknowledge if any, clamp at max.
    always_comb begin
        sum = {1'b0, cnt_q} + {{PEND_W{1'b0}}, tick_i};
        if (ack_i && cnt_q != '0)
            sum = sum - 1'b1;
        cnt_d = (sum > PEND_MAX) ? PEND_MAX[PEND_W-1:0] : sum[PEND_W-1:0];
    end

    // Register the count and the interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            irq_q <= !ack_i && (cnt_d != '0);
        end
    end

    assign count_o = cnt_q;
    assign irq_o   = irq_q;
endmodule

// File: rtl/rtc_tick_unit.sv
// Top: seconds counter readable in three 16-bit registers plus a periodic
// interrupt with a pending-tick counter. Reads are combinational; writes
// and acknowledges take effect at the clock edge of the access cycle.
module rtc_tick_unit
    import rtc_pkg::*;
#(
    parameter int          ADDR_W  = 12,
    parameter int          SEC_DIV = 32768,
    parameter logic [11:0] ACK_OFF = 12'h1DE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq
);
    logic [SEC_W-1:0]  sec_val;
    logic [REG_W-1:0]  rate_div;
    logic [PEND_W-1:0] pend_cnt;
    logic              per_tick;
    logic              rate_load;
    logic              ack_hit;

    // Decode divisor load and acknowledge access.
    always_comb begin
        rate_load = bus_sel && bus_we && (bus_addr == ADDR_W'(OFF_RATE))
                    && (bus_wdata != '0);
        ack_hit   = bus_sel && (bus_addr == ADDR_W'(ACK_OFF));
    end

    rtc_sec_counter #(.SEC_DIV(SEC_DIV), .SEC_W(SEC_W)) u_sec (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .sec_o(sec_val)
    );

    rtc_rate_divider #(.DIV_W(REG_W)) u_div (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
        .load_i(rate_load), .div_i(bus_wdata),
        .div_o(rate_div), .tick_o(per_tick)
    );

    rtc_pending_ctr #(.PEND_W(PEND_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .tick_i(per_tick), .ack_i(ack_hit),
        .count_o(pend_cnt), .irq_o(irq)
    );

    // Read multiplexer for the seconds registers.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            if (bus_addr == ADDR_W'(OFF_SEC_LO))
                bus_rdata = {sec_val[0], {(REG_W-1){1'b0}}};
            else if (bus_addr == ADDR_W'(OFF_SEC_MID))
                bus_rdata = sec_val[REG_W:1];
            else if (bus_addr == ADDR_W'(OFF_SEC_HI))
                bus_rdata = sec_val[SEC_W-1:REG_W+1];
        end
    end
endmodule

// File: rtl/rtc_tick_unit_chk.sv
// Checker for rtc_tick_unit: protocol properties between the sub-blocks.
module rtc_tick_unit_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic              ack_hit,
    input logic              per_tick,
    input logic              irq,
    input logic [7:0]        pend_cnt,
    input logic [15:0]       rate_div,
    input logic [32:0]       sec_val
);
    AST_SEC_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sec_val >= $past(sec_val)); // R1

    AST_ZERO_RATE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == ADDR_W'(12'h0D0) && bus_wdata == 16'h0)
        |=> $stable(rate_div)); // R5

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend_cnt != 8'h0); // R7

    AST_TICK_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (per_tick && !ack_hit) |=> irq); // R7

    AST_ACK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |=> !irq); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_cnt == 8'hFF && !ack_hit) |=> pend_cnt == 8'hFF); // R9
endmodule

bind rtc_tick_unit rtc_tick_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ack_hit(ack_hit),
    .per_tick(per_tick), .irq(irq), .pend_cnt(pend_cnt),
    .rate_div(rate_div), .sec_val(sec_val)
);

// File: tb/rtc_tick_unit_bench.sv
// Directed bench for rtc_tick_unit, one task per scenario.
module rtc_tick_unit_bench;
    localparam int ADDR_W = 12;
    localparam logic [11:0] ACK = 12'h1DE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int   n_chk = 0;
    int   n_fail = 0;
    longint exp_sec = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    rtc_tick_unit #(.ADDR_W(ADDR_W), .SEC_DIV(1), .ACK_OFF(ACK)) u_rtc_tick_unit (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus(input logic we, input logic [11:0] a, input logic [15:0] d,
                       output logic [15:0] q);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        #1 q = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            base_tick = 1'b1;
            @(negedge clk);
            base_tick = 1'b0;
            exp_sec++;
        end
    endtask

    // Acknowledge n pending ticks, checking gap and re-assertion each time.
    task automatic drain(input int n, input string req);
        logic [15:0] q;
        for (int i = 0; i < n; i++) begin
            bus(1'b0, ACK, 16'h0, q);
            check({req, " irq gap after ack"}, irq, 0);
            @(negedge clk);
            check({req, " irq after gap"}, irq, (i < n - 1) ? 1 : 0);
        end
    endtask

    task automatic read_secs(input string req);
        logic [15:0] q;
        bus(1'b0, 12'h0C0, 16'h0, q);
        check({req, " sec lo"}, q, (exp_sec & 1) << 15);
        bus(1'b0, 12'h0C2, 16'h0, q);
        check({req, " sec mid"}, q, (exp_sec >> 1) & 16'hFFFF);
        bus(1'b0, 12'h0C4, 16'h0, q);
        check({req, " sec hi"}, q, (exp_sec >> 17) & 16'hFFFF);
    endtask

    task automatic t_reset;
        check("R1 irq at reset", irq, 0);
        read_secs("R1 reset");
    endtask

    task automatic t_idle;
        pulses(10);
        check("R6 no irq before divisor", irq, 0);
        read_secs("R2 R3 even");
        pulses(1);
        read_secs("R2 R3 odd");
    endtask

    task automatic t_rate;
        logic [15:0] q;
        bus(1'b1, 12'h0D0, 16'd3, q);
        pulses(2);
        check("R4 no tick before Nth pulse", irq, 0);
        pulses(1);
        check("R4 tick on Nth pulse", irq, 1);
        drain(1, "R8 single");
        pulses(6);
        check("R7 two ticks pending", irq, 1);
        drain(2, "R8 double");
    endtask

    task automatic t_ignored;
        logic [15:0] q;
        bus(1'b1, 12'h0D0, 16'd0, q);
        bus(1'b1, 12'h0D2, 16'd7, q);
        pulses(2);
        check("R5 divisor kept after zero write", irq, 0);
        pulses(1);
        check("R5 tick keeps phase", irq, 1);
        bus(1'b1, ACK, 16'h0, q);
        check("R8 write access acks", irq, 0);
        @(negedge clk);
        check("R8 empty after write ack", irq, 0);
    endtask

    task automatic t_saturate;
        logic [15:0] q;
        bus(1'b1, 12'h0D0, 16'd1, q);
        pulses(300);
        check("R9 irq at saturation", irq, 1);
        drain(255, "R9 drain");
        pulses(1);
        check("R9 counting resumes", irq, 1);
        drain(1, "R9 tail");
    endtask

    task automatic t_long;
        @(negedge clk);
        base_tick = 1'b1;
        repeat (132000) begin
            @(negedge clk);
            exp_sec++;
        end
        base_tick = 1'b0;
        read_secs("R3 upper register");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_rate();
        t_ignored();
        t_saturate();
        t_long();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule